// File: doc/BRIEF.md
# SMII Transmit Segment Deserializer

This block sits on the PHY side of a Serial MII link and turns the single-bit transmit line back into per-byte MII transmit signals. The link carries ten-bit segments, and the MAC marks the start of each one with a SYNC pulse once every ten cycles of the 125 MHz reference. The block locks onto SYNC and collects the ten bits of each segment. It then presents the byte together with transmit-enable and transmit-error flags, and raises a one-cycle byte strobe for each byte it delivers.

A speed input picks the rate. At 100 Mbps every complete segment becomes a new byte. At 10 Mbps the MAC sends each segment ten times in a row, and the block delivers one segment out of each group of ten. A modulo-ten repetition counter makes that choice, and the counter is re-aligned whenever transmit-enable rises. If SYNC arrives at any spacing other than ten cycles, the block drops the partial segment, pulses a sync-error flag and starts alignment again from the new SYNC.

Top module: `smii_tx_deser`

## Requirements
- R1: While rst_ni is low, and in the first cycle after release, byte_stb_o, sync_err_o, tx_en_o, tx_er_o and data_o are all 0.
- R2: Bit 0 of a segment is sampled in the cycle where sync_i is high and goes to tx_er_o. Bit 1 goes to tx_en_o. Bits 2 to 9 go to data_o[0] through data_o[7], in that order, least significant bit first.
- R3: When a segment is delivered, byte_stb_o is high for exactly one cycle. That cycle immediately follows the clock edge that sampled the tenth bit. The data_o, tx_en_o and tx_er_o outputs change only together with byte_stb_o and keep their value between strobes.
- R4: With speed_10_i low (100 Mbps), every complete segment is delivered.
- R5: With speed_10_i high (10 Mbps), a modulo-10 repetition counter advances on each complete segment, and only the segment that finds the counter at 0 is delivered. On entry to 10 Mbps the counter is at 0.
- R6: At 10 Mbps, a complete segment whose bit 1 is 1 after a complete segment whose bit 1 was 0 is always delivered, and the counter restarts from it. The next delivered segment is therefore the tenth one after it.
- R7: If a SYNC arrives when the previous one was not exactly ten cycles earlier, sync_err_o is high for one cycle, the partial segment is not delivered, and bit 0 of a new segment is sampled in that SYNC cycle.
- R8: Before the first SYNC after reset, no byte is strobed and no sync error is raised, whatever tx_i carries.
- R9: The first SYNC after reset does not raise sync_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 125 MHz reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| speed_10_i | input | 1 | 1 selects 10 Mbps, 0 selects 100 Mbps |
| sync_i | input | 1 | Segment start pulse, high during bit 0 |
| tx_i | input | 1 | Serial transmit data and control line |
| data_o | output | 8 | Recovered transmit byte |
| tx_en_o | output | 1 | Recovered transmit enable |
| tx_er_o | output | 1 | Recovered transmit error |
| byte_stb_o | output | 1 | One-cycle pulse for each delivered byte |
| sync_err_o | output | 1 | One-cycle pulse on a misplaced SYNC |

## Verification
If the bit-position counter is off by even one, the byte delivered ten cycles later comes out shifted: the flag bits land in the wrong outputs, or the strobe appears one cycle early or late. A lost lock shows up as a missing strobe or as a sync error on the next SYNC. A 10 Mbps repetition counter that is misaligned shows up only when a segment is delivered. That can take up to ten segments, about one hundred cycles, and appears as an idle byte where the first frame byte belongs, or as a strobe in the middle of a repeat group. The reference model is compared against all five outputs on every clock, so any of these faults is reported in the cycle where it first appears.

// File: rtl/smii_pkg.sv
package smii_pkg;
  localparam int unsigned SEG_BITS = 10;
  localparam int unsigned DATA_W   = SEG_BITS - 2;
  localparam int unsigned ER_IDX   = 0;
  localparam int unsigned EN_IDX   = 1;
  localparam int unsigned POS_W    = $clog2(SEG_BITS + 1);

  typedef struct packed {
    logic              er;
    logic              en;
    logic [DATA_W-1:0] data;
  } mii_byte_t;
endpackage

// File: rtl/smii_seg_align.sv
module smii_seg_align
  import smii_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sync_i,
  input  logic                tx_i,
  output logic                seg_done_o,
  output logic [SEG_BITS-1:0] seg_bits_o,
  output logic                sync_err_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(SEG_BITS - 1);
  localparam logic [POS_W-1:0] OVR  = POS_W'(SEG_BITS);

  logic [POS_W-1:0]    pos_q;
  logic [POS_W-1:0]    nxt_pos;
  logic                locked_q;
  logic [SEG_BITS-2:0] shift_q;
  logic                err_q;

  assign nxt_pos = pos_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      locked_q <= 1'b0;
      shift_q  <= '0;
      err_q    <= 1'b0;
    end else begin
      // spacing is good only if the previous edge took bit 9
      err_q <= sync_i && locked_q && (pos_q != LAST);
      if (sync_i) begin
        locked_q <= 1'b1;
        pos_q    <= '0;
        shift_q  <= {{(SEG_BITS-2){1'b0}}, tx_i};
      end else if (locked_q && pos_q < OVR) begin
        pos_q <= nxt_pos;
        if (nxt_pos < LAST) shift_q[nxt_pos] <= tx_i;
      end
    end
  end

  // tenth bit is on tx_i this cycle
  assign seg_done_o = locked_q && !sync_i && (pos_q == LAST - 1'b1);
  assign seg_bits_o = {tx_i, shift_q};
  assign sync_err_o = err_q;

  // R7
  sync_realign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (locked_q && pos_q == '0));
endmodule

// File: rtl/smii_rep_sel.sv
module smii_rep_sel #(
  parameter int unsigned REP_COUNT = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic speed_10_i,
  input  logic seg_done_i,
  input  logic seg_en_i,
  output logic use_o
);
  localparam int unsigned REP_W = (REP_COUNT > 1) ? $clog2(REP_COUNT) : 1;
  localparam logic [REP_W-1:0] REP_LAST = REP_W'(REP_COUNT - 1);

  logic [REP_W-1:0] rep_q;
  logic [REP_W-1:0] base;
  logic [REP_W-1:0] rep_nxt;
  logic             prev_en_q;
  logic             rise;

  assign rise    = seg_en_i && !prev_en_q;
  assign base    = rise ? '0 : rep_q;
  assign rep_nxt = (base == REP_LAST) ? '0 : base + 1'b1;
  assign use_o   = !speed_10_i || (base == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rep_q     <= '0;
      prev_en_q <= 1'b0;
    end else if (seg_done_i) begin
      prev_en_q <= seg_en_i;
      rep_q     <= speed_10_i ? rep_nxt : '0;
    end
  end

  // R5
  rep_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_done_i && speed_10_i && use_o) |=> (rep_q == ((REP_COUNT > 1) ? REP_W'(1) : '0)));
endmodule

// File: rtl/smii_tx_deser.sv
module smii_tx_deser
  import smii_pkg::*;
#(
  parameter int unsigned REP_COUNT = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              speed_10_i,
  input  logic              sync_i,
  input  logic              tx_i,
  output logic [DATA_W-1:0] data_o,
  output logic              tx_en_o,
  output logic              tx_er_o,
  output logic              byte_stb_o,
  output logic              sync_err_o
);
  logic                seg_done;
  logic [SEG_BITS-1:0] seg_bits;
  logic                use_seg;
  mii_byte_t           dec;
  mii_byte_t           out_q;
  logic                stb_q;

  smii_seg_align u_align (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync_i),
    .tx_i       (tx_i),
    .seg_done_o (seg_done),
    .seg_bits_o (seg_bits),
    .sync_err_o (sync_err_o)
  );

  assign dec.er   = seg_bits[ER_IDX];
  assign dec.en   = seg_bits[EN_IDX];
  assign dec.data = seg_bits[SEG_BITS-1:2];

  smii_rep_sel #(.REP_COUNT(REP_COUNT)) u_rep (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .speed_10_i (speed_10_i),
    .seg_done_i (seg_done),
    .seg_en_i   (dec.en),
    .use_o      (use_seg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= seg_done && use_seg;
      if (seg_done && use_seg) out_q <= dec;
    end
  end

  assign data_o     = out_q.data;
  assign tx_en_o    = out_q.en;
  assign tx_er_o    = out_q.er;
  assign byte_stb_o = stb_q;

  // R3
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_stb_o |=> !byte_stb_o);
  // R7
  err_strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byte_stb_o && sync_err_o));
endmodule

// File: tb/tb_smii_tx_deser.sv
module tb_smii_tx_deser;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       speed_10 = 1'b0;
  logic       sync = 1'b0;
  logic       tx = 1'b0;
  logic [7:0] data_o;
  logic       tx_en_o, tx_er_o, byte_stb_o, sync_err_o;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  smii_tx_deser dut (
    .clk_i(clk), .rst_ni(rst_n), .speed_10_i(speed_10), .sync_i(sync), .tx_i(tx),
    .data_o(data_o), .tx_en_o(tx_en_o), .tx_er_o(tx_er_o),
    .byte_stb_o(byte_stb_o), .sync_err_o(sync_err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit   q[$];
  int   m_cnt = 0;
  bit   m_locked = 0;
  int   m_rep = 0;
  bit   m_prev = 0;
  bit   m_stb = 0, m_err = 0, m_en = 0, m_er = 0;
  logic [7:0] m_data = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_cnt = 0; m_locked = 0; m_rep = 0; m_prev = 0;
      m_stb = 0; m_err = 0; m_en = 0; m_er = 0; m_data = '0;
    end else begin
      m_stb = 0;
      m_err = 0;
      if (sync) begin
        if (m_locked && m_cnt != 10) m_err = 1;
        q.delete();
        q.push_back(tx);
        m_cnt = 1;
        m_locked = 1;
      end else if (m_locked) begin
        if (m_cnt < 10) begin
          q.push_back(tx);
          m_cnt++;
          if (m_cnt == 10) begin
            bit en_b, take, rise;
            en_b = q[1];
            take = 1;
            if (speed_10) begin
              rise = en_b && !m_prev;
              if (rise) m_rep = 0;
              take = (m_rep == 0);
              m_rep = (m_rep + 1) % 10;
            end else m_rep = 0;
            m_prev = en_b;
            if (take) begin
              m_stb = 1; m_er = q[0]; m_en = en_b;
              for (int k = 0; k < 8; k++) m_data[k] = q[k+2];
            end
          end
        end else m_cnt = 11;
      end
    end
  end

  // per-cycle compare and event tallies
  int stb_cnt = 0, err_cnt = 0;
  logic [7:0] en_bytes[$];

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(byte_stb_o == m_stb, "R3 strobe", byte_stb_o, m_stb);
      chk(sync_err_o == m_err, "R7 sync_err", sync_err_o, m_err);
      chk(tx_en_o == m_en, "R2 tx_en", tx_en_o, m_en);
      chk(tx_er_o == m_er, "R2 tx_er", tx_er_o, m_er);
      chk(data_o == m_data, "R2 data", data_o, m_data);
      if (byte_stb_o) stb_cnt++;
      if (sync_err_o) err_cnt++;
      if (byte_stb_o && tx_en_o) en_bytes.push_back(data_o);
    end
  end

  task automatic drive(input bit s, input bit b);
    @(negedge clk);
    sync = s;
    tx = b;
  endtask

  task automatic send_seg(input bit er, input bit en, input logic [7:0] d, input int len = 10);
    for (int i = 0; i < len; i++) begin
      bit b;
      b = (i == 0) ? er : (i == 1) ? en : (i < 10) ? d[i-2] : 1'b0;
      drive(i == 0, b);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=0 expected=1");
    misses++;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [7:0] frame[3];
    int s0, e0;
    frame[0] = 8'h5A; frame[1] = 8'hC3; frame[2] = 8'h81;

    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk({byte_stb_o, sync_err_o, tx_en_o, tx_er_o, data_o} == '0, "R1 reset outputs",
        {byte_stb_o, sync_err_o, tx_en_o, tx_er_o, data_o}, 0);
    rst_n = 1'b1;
    settle();
    chk({byte_stb_o, sync_err_o, tx_en_o, tx_er_o, data_o} == '0, "R1 after release",
        {byte_stb_o, sync_err_o, tx_en_o, tx_er_o, data_o}, 0);

    // R8 no activity before first SYNC
    for (int i = 0; i < 25; i++) drive(1'b0, i[0] ^ i[2]);
    settle();
    chk(stb_cnt == 0, "R8 no strobe before sync", stb_cnt, 0);
    chk(err_cnt == 0, "R8 no error before sync", err_cnt, 0);

    // R4 100 Mbps: every segment delivered
    send_seg(1'b0, 1'b1, 8'hA5);
    send_seg(1'b1, 1'b0, 8'h01);
    send_seg(1'b0, 1'b0, 8'h80);
    send_seg(1'b1, 1'b1, 8'hFF);
    send_seg(1'b0, 1'b1, 8'h00);
    send_seg(1'b1, 1'b0, 8'h3C);
    settle();
    chk(stb_cnt == 6, "R4 one strobe per segment", stb_cnt, 6);
    chk(err_cnt == 0, "R9 first sync no error", err_cnt, 0);
    chk(data_o == 8'h3C, "R2 last byte", data_o, 8'h3C);
    chk({tx_er_o, tx_en_o} == 2'b10, "R2 last flags", {tx_er_o, tx_en_o}, 2'b10);

    // R7 overrun, then a short segment
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b1);
    s0 = stb_cnt; e0 = err_cnt;
    send_seg(1'b0, 1'b1, 8'h11);
    send_seg(1'b1, 1'b1, 8'h77, 4);
    send_seg(1'b0, 1'b1, 8'h96);
    settle();
    chk(err_cnt - e0 == 2, "R7 misplaced syncs flagged", err_cnt - e0, 2);
    chk(stb_cnt - s0 == 2, "R7 partial dropped", stb_cnt - s0, 2);
    chk(data_o == 8'h96, "R7 realigned byte", data_o, 8'h96);

    // R5/R6 10 Mbps
    @(negedge clk);
    speed_10 = 1'b1;
    s0 = stb_cnt;
    en_bytes.delete();
    for (int i = 0; i < 12; i++) send_seg(1'b0, 1'b0, 8'h00);
    settle();
    chk(stb_cnt - s0 == 2, "R5 one in ten idle", stb_cnt - s0, 2);
    for (int b = 0; b < 3; b++)
      for (int r = 0; r < 10; r++) send_seg(1'b0, 1'b1, frame[b]);
    for (int i = 0; i < 10; i++) send_seg(1'b0, 1'b0, 8'h00);
    settle();
    chk(en_bytes.size() == 3, "R6 frame bytes delivered", en_bytes.size(), 3);
    for (int b = 0; b < 3; b++)
      if (b < en_bytes.size())
        chk(en_bytes[b] == frame[b], "R6 frame byte order", en_bytes[b], frame[b]);
    chk(stb_cnt - s0 == 6, "R5 strobes in 10M run", stb_cnt - s0, 6);
    chk(tx_en_o == 1'b0, "R5 idle after frame", tx_en_o, 0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule